// File: doc/BRIEF.md
# Johnson Counter Timing Generator

This block produces a set of timing strobes that take turns in a fixed order. A K-bit twisted-ring shift register is at its core. Each enabled clock moves the register one position. The inverted top bit enters at the bottom, so the register visits 2K distinct patterns before it returns to zero.

A small decoder turns each of those patterns into a single active strobe, so 2K one-hot phase outputs advance by one position per enabled clock. Because of the twisted feedback, each phase needs only a two-input AND gate. That gate looks at the two end bits, or at one pair of neighbouring bits.

The register contents are also brought out, so a user can take the coarse half-period signals directly. Control sequencers use the block to step through a repeating series of operations. Any register pattern that the sequence cannot reach is cleared on the next clock, so the block recovers by itself.

Top module: `johnson_timer`

## Requirements
- R1: While `clr_n` is low, `stage_q` is all zeros and only `phase[0]` is high. The clear acts without waiting for a clock edge.
- R2: On a clock edge with `en` high and a legal register value, `stage_q[0]` takes the inverse of the old `stage_q[K-1]`, and each `stage_q[i]` for i ≥ 1 takes the old `stage_q[i-1]`.
- R3: Starting from zero, the register passes through 2K distinct values and is zero again after exactly 2K enabled clocks. For K = 4 the values are 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000.
- R4: For every legal register value, exactly one bit of `phase` is high. After s enabled clocks from zero (counted modulo 2K), that bit is `phase[s]`.
- R5: `phase[0]` is high exactly when `stage_q[0]` and `stage_q[K-1]` are both 0. `phase[K]` is high exactly when both are 1.
- R6: For 1 ≤ i ≤ K-1, `phase[i]` is high exactly when `stage_q[i-1]`=1 and `stage_q[i]`=0. `phase[K+i]` is high exactly when `stage_q[i-1]`=0 and `stage_q[i]`=1.
- R7: With `en` low and a legal register value, `stage_q` and `phase` keep their values across clock edges.
- R8: A register value is legal when at most one neighbouring bit pair differs. An illegal value is replaced by all zeros on the next clock edge, whatever the level of `en`.
- R9: The strobe wraps around: an enabled clock taken while `phase[2K-1]` is high makes `phase[0]` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| en | input | 1 | Advance enable |
| stage_q | output | K | Raw twisted-ring register bits |
| phase | output | 2K | One-hot decoded timing strobes |

## Verification
The checker watches four properties on every cycle:
- each legal step moves the register by one position;
- the register holds while the enable is low;
- exactly one strobe is active in any legal state;
- an illegal value is cleared on the next edge, and the strobe wraps from the last phase to the first.

Only the bench's scenarios can show three further points:
- the full numeric order of states after a clear, and its return to zero after 2K steps;
- the position of each strobe relative to the step count;
- recovery from specific corrupted patterns, which the bench plants in the register while the clear is held.

// File: rtl/johnson_timer.sv
module johnson_timer #(
  parameter int K = 4
) (
  input  logic           clk,
  input  logic           clr_n,
  input  logic           en,
  output logic [K-1:0]   stage_q,
  output logic [2*K-1:0] phase
);
  localparam int N = 2 * K;

  logic [K-1:0] q_r;
  logic [K-2:0] edges;
  logic         legal;

  assign edges = q_r[K-1:1] ^ q_r[K-2:0];
  assign legal = (edges & (edges - 1'b1)) == '0;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)     q_r <= '0;
    else if (!legal) q_r <= '0;
    else if (en)    q_r <= {q_r[K-2:0], ~q_r[K-1]};
  end

  assign stage_q = q_r;

  logic [N-1:0] dec;
  assign dec[0] = ~q_r[0] & ~q_r[K-1];
  assign dec[K] =  q_r[0] &  q_r[K-1];

  for (genvar i = 1; i < K; i++) begin : g_dec
    assign dec[i]     =  q_r[i-1] & ~q_r[i];
    assign dec[K + i] = ~q_r[i-1] &  q_r[i];
  end

  assign phase = dec;
endmodule

// File: rtl/johnson_timer_chk.sv
module johnson_timer_chk #(
  parameter int K = 4
) (
  input logic           clk,
  input logic           clr_n,
  input logic           en,
  input logic [K-1:0]   stage_q,
  input logic [2*K-1:0] phase
);
  logic ok;
  assign ok = $countones(stage_q[K-1:1] ^ stage_q[K-2:0]) <= 1;

  // R2
  step_shift_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (en && ok) |=> stage_q == {$past(stage_q[K-2:0]), ~$past(stage_q[K-1])});

  // R4
  one_phase_chk: assert property (@(posedge clk) disable iff (!clr_n)
    ok |-> $onehot(phase));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!en && ok) |=> ($stable(stage_q) && $stable(phase)));

  // R8
  recover_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !ok |=> stage_q == '0);

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (en && ok && phase[2*K-1]) |=> phase[0]);
endmodule

bind johnson_timer johnson_timer_chk #(.K(K)) u_chk (
  .clk(clk), .clr_n(clr_n), .en(en), .stage_q(stage_q), .phase(phase)
);

// File: tb/tb_johnson_timer.sv
module tb_johnson_timer;
  localparam int K = 4;
  localparam int N = 2 * K;

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic en = 1'b0;
  logic [K-1:0] stage_q;
  logic [N-1:0] phase;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  johnson_timer #(.K(K)) dut (
    .clk(clk), .clr_n(clr_n), .en(en), .stage_q(stage_q), .phase(phase)
  );

  always #10 clk = ~clk;

  function automatic logic [K-1:0] exp_q(int s);
    logic [K-1:0] v;
    if (s <= K) v = K'((1 << s) - 1);
    else        v = ~K'((1 << (s - K)) - 1);
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic check_state(int s, string tag);
    chk(stage_q == exp_q(s), tag, 32'(stage_q), 32'(exp_q(s)));
    chk(phase == N'(1 << s), tag, 32'(phase), 32'(1 << s));
  endtask

  task automatic t_reset();
    clr_n = 1'b0; en = 1'b0;
    repeat (2) @(negedge clk);
    check_state(0, "R1 reset state");
    clr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_sequence();
    en = 1'b1;
    for (int s = 1; s <= 2 * N; s++) begin
      @(negedge clk);
      check_state(s % N, "R2 R3 R4 step");
      chk((phase[0] == (!stage_q[0] && !stage_q[K-1])) &&
          (phase[K] == (stage_q[0] && stage_q[K-1])),
          "R5 end decode", 32'(phase), 32'(1 << (s % N)));
      for (int i = 1; i < K; i++) begin
        chk(phase[i] == (stage_q[i-1] && !stage_q[i]) &&
            phase[K+i] == (!stage_q[i-1] && stage_q[i]),
            "R6 pair decode", 32'(phase), 32'(1 << (s % N)));
      end
      if (s % N == 0) chk(stage_q == '0, "R9 wrap to zero", 32'(stage_q), 0);
    end
    en = 1'b0;
  endtask

  task automatic t_hold();
    en = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
    check_state(3, "R7 hold");
    en = 1'b1;
    @(negedge clk);
    check_state(4, "R7 resume");
    en = 1'b0;
  endtask

  task automatic t_recover(logic [K-1:0] bad, bit en_lvl);
    clr_n = 1'b0; en = en_lvl;
    @(negedge clk);
    force dut.q_r = bad;
    #1 release dut.q_r;
    #1 clr_n = 1'b1;
    #1 chk(stage_q == bad, "R8 planted", 32'(stage_q), 32'(bad));
    @(negedge clk);
    check_state(0, "R8 recover");
    en = 1'b0;
  endtask

  task automatic t_async_clear();
    en = 1'b1;
    repeat (5) @(negedge clk);
    #3 clr_n = 1'b0;
    #1 check_state(0, "R1 async clear");
    @(negedge clk);
    clr_n = 1'b1; en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_reset();
    t_hold();
    t_recover(4'b0101, 1'b1);
    t_recover(4'b1011, 1'b0);
    t_reset();
    t_async_clear();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule